// File: doc/BRIEF.md
# Configurable Logic Cell for a Four-Pin Port Group

This block is a small programmable logic element attached to a group of four general-purpose pins. Three of the pins feed it, and the fourth is driven from its result. A 6-bit configuration word selects one of two functions. The first is a two-input exclusive-OR, and each of its two inputs can be inverted on its own. The second is a three-input AND or OR gate. Its input inversions are chosen by a 3-bit code from a fixed table of eight patterns, not by one bit per input.

The result passes through a registered output stage, so the driven pin changes only on a clock edge. With the default depth of one stage, any change to the inputs or to the configuration appears at the output on the first rising clock edge that samples it. The pipeline depth is a parameter. Register access and pin electrical behaviour are handled elsewhere.

Top module: `cla_cell`

## Requirements
- R1: While `rst_n` is low the output `out_o` is 0, and asserting `rst_n` low forces `out_o` to 0 at once, without waiting for a clock edge.
- R2: With the default `STAGES`=1, `out_o` takes the value computed from `cfg_i` and `pin_i` as they stand at a rising edge of `clk`, and holds it until the next rising edge.
- R3: When `cfg_i[5]` is 0 (XOR mode), `out_o` = (`pin_i[0]` XOR `cfg_i[0]`) XOR (`pin_i[1]` XOR `cfg_i[1]`). Here `cfg_i[0]`=1 inverts `pin_i[0]` and `cfg_i[1]`=1 inverts `pin_i[1]`.
- R4: In XOR mode, `pin_i[2]` and `cfg_i[4:2]` have no effect on `out_o`.
- R5: When `cfg_i[5]` is 1 and `cfg_i[4]` is 0, `out_o` is the AND of the three inputs `pin_i[2:0]` after the inversion selected by `cfg_i[2:0]`.
- R6: When `cfg_i[5]` is 1 and `cfg_i[4]` is 1, `out_o` is the OR of the three inputs after that same inversion.
- R7: The inversion code `cfg_i[2:0]` selects which inputs are inverted, as follows. Code 0 inverts none. Code 1 inverts `pin_i[0]`. Code 2 inverts `pin_i[1]`. Code 3 inverts `pin_i[2]`. Code 4 inverts `pin_i[0]` and `pin_i[1]`. Code 5 inverts `pin_i[0]` and `pin_i[2]`. Code 6 inverts `pin_i[1]` and `pin_i[2]`. Code 7 inverts all three.
- R8: Bit `cfg_i[3]` is reserved and has no effect on `out_o` in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 6 | Configuration word: [5] function, [4] OR select, [3] reserved, [2:0] inversion code |
| pin_i | input | 3 | Input pins of the group: [0], [1] and [2] |
| out_o | output | 1 | Registered result that drives the group's output pin |

## Verification
The only state in this block is the output register. A wrong value there appears on `out_o` in the cycle right after the edge that captured it, and is replaced on the following edge unless the same error repeats. A misrouted inversion code or a swapped input therefore shows up as a single-cycle mismatch for particular combinations of configuration and input only. For that reason the bench sweeps all 64 configuration words against all 8 input patterns and compares every cycle. It also checks that a reset clears the register immediately rather than at the next clock edge.

// File: rtl/cla_pkg.sv
package cla_pkg;
   localparam int CFG_W    = 6;
   localparam int N_IN     = 3;
   localparam int CODE_W   = 3;
   localparam int MODE_BIT = 5;
   localparam int OR_BIT   = 4;
   localparam int RSVD_BIT = 3;

   typedef enum logic {
      CLA_XOR2  = 1'b0,
      CLA_GATE3 = 1'b1
   } cla_mode_e;

   typedef enum logic {
      CLA_AND = 1'b0,
      CLA_OR  = 1'b1
   } cla_op_e;
endpackage

// File: rtl/cla_inv_decode.sv
module cla_inv_decode
   import cla_pkg::*;
#(
   parameter int N = N_IN
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [N-1:0]      mask_o
);
   if (N != 3) begin : g_bad_n
      $error("cla_inv_decode supports exactly three inputs");
   end

   always_comb begin
      case (code_i)
         3'd0:    mask_o = 3'b000;
         3'd1:    mask_o = 3'b001;
         3'd2:    mask_o = 3'b010;
         3'd3:    mask_o = 3'b100;
         3'd4:    mask_o = 3'b011;
         3'd5:    mask_o = 3'b101;
         3'd6:    mask_o = 3'b110;
         default: mask_o = 3'b111;
      endcase
   end
endmodule

// File: rtl/cla_xor2.sv
module cla_xor2 (
   input  logic [1:0] pin_i,
   input  logic [1:0] inv_i,
   output logic       y_o
);
   logic [1:0] cond;
   assign cond = pin_i ^ inv_i;
   assign y_o  = cond[0] ^ cond[1];
endmodule

// File: rtl/cla_gate3.sv
module cla_gate3
   import cla_pkg::*;
#(
   parameter int N = N_IN
) (
   input  logic [N-1:0] pin_i,
   input  logic [N-1:0] mask_i,
   input  cla_op_e      op_i,
   output logic         y_o
);
   logic [N-1:0] cond;

   for (genvar k = 0; k < N; k++) begin : g_inv
      assign cond[k] = mask_i[k] ? ~pin_i[k] : pin_i[k];
   end

   assign y_o = (op_i == CLA_OR) ? (|cond) : (&cond);
endmodule

// File: rtl/cla_out_pipe.sv
module cla_out_pipe #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] pipe_q;

   if (STAGES < 1) begin : g_bad_stages
      $error("cla_out_pipe needs at least one stage");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= d_i;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cla_cell.sv
module cla_cell
   import cla_pkg::*;
#(
   parameter int STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg_i,
   input  logic [N_IN-1:0]  pin_i,
   output logic             out_o
);
   if (CFG_W != 6) begin : g_bad_cfg
      $error("cla_cell expects a 6-bit configuration word");
   end

   cla_mode_e        mode;
   cla_op_e          op;
   logic [N_IN-1:0]  mask;
   logic             xor_y;
   logic             gate_y;
   logic             next_y;
   logic             cfg_unused;

   assign mode       = cla_mode_e'(cfg_i[MODE_BIT]);
   assign op         = cla_op_e'(cfg_i[OR_BIT]);
   assign cfg_unused = cfg_i[RSVD_BIT];

   cla_inv_decode #(.N(N_IN)) u_dec (
      .code_i (cfg_i[CODE_W-1:0]),
      .mask_o (mask)
   );

   cla_xor2 u_xor (
      .pin_i (pin_i[1:0]),
      .inv_i (cfg_i[1:0]),
      .y_o   (xor_y)
   );

   cla_gate3 #(.N(N_IN)) u_gate (
      .pin_i  (pin_i),
      .mask_i (mask),
      .op_i   (op),
      .y_o    (gate_y)
   );

   assign next_y = (mode == CLA_GATE3) ? gate_y : xor_y;

   cla_out_pipe #(.STAGES(STAGES)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (next_y),
      .q_o   (out_o)
   );
endmodule

// File: rtl/cla_cell_chk.sv
module cla_cell_chk #(
   parameter int STAGES = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [5:0] cfg_i,
   input logic [2:0] pin_i,
   input logic       out_o
);
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_low: assert (out_o == 1'b0)
            else $error("output not low in reset");
      end
   end

   if (STAGES == 1) begin : g_one
      a_r3_xor_path: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(cfg_i[5])) |->
            out_o == ($past(pin_i[0]) ^ $past(cfg_i[0]) ^ $past(pin_i[1]) ^ $past(cfg_i[1])));

      a_r5_and_plain: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(cfg_i[5:4]) == 2'b10 && $past(cfg_i[2:0]) == 3'd0)
            |-> out_o == (&$past(pin_i)));

      a_r6_or_plain: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(cfg_i[5:4]) == 2'b11 && $past(cfg_i[2:0]) == 3'd0)
            |-> out_o == (|$past(pin_i)));

      a_r7_all_inverted: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(cfg_i[5:4]) == 2'b10 && $past(cfg_i[2:0]) == 3'd7)
            |-> out_o == ($past(pin_i) == 3'b000));

      a_r2_holds: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $stable(cfg_i) && $stable(pin_i) && $past(rst_n, 2))
            |=> $stable(out_o));
   end
endmodule

bind cla_cell cla_cell_chk #(.STAGES(STAGES)) chk_i (
   .clk   (clk),
   .rst_n (rst_n),
   .cfg_i (cfg_i),
   .pin_i (pin_i),
   .out_o (out_o)
);

// File: tb/cla_cell_tb_top.sv
module cla_cell_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] cfg = '0;
   logic [2:0] pin = '0;
   logic       out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic  exp;
      string tag;
      int    cfgv;
      int    pinv;
   } item_t;
   item_t sb_q[$];

   always #10 clk = ~clk;

   cla_cell dut_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg_i (cfg),
      .pin_i (pin),
      .out_o (out)
   );

   function automatic logic [2:0] inv_pattern(input logic [2:0] code);
      // R7 table: bit0 = pin[0], bit1 = pin[1], bit2 = pin[2]
      logic [2:0] m;
      case (code)
         3'd0: m = 3'b000;
         3'd1: m = 3'b001;
         3'd2: m = 3'b010;
         3'd3: m = 3'b100;
         3'd4: m = 3'b011;
         3'd5: m = 3'b101;
         3'd6: m = 3'b110;
         default: m = 3'b111;
      endcase
      return m;
   endfunction

   function automatic logic model(input logic [5:0] c, input logic [2:0] p);
      logic [2:0] v;
      if (!c[5]) return (p[0] ^ c[0]) ^ (p[1] ^ c[1]);
      v = p ^ inv_pattern(c[2:0]);
      return c[4] ? (v != 3'b000) : (v == 3'b111);
   endfunction

   function automatic string tag_of(input logic [5:0] c);
      string t;
      if (!c[5]) t = "R2 R3 R4";
      else if (c[4]) t = "R2 R6 R7";
      else t = "R2 R5 R7";
      if (c[3]) t = {t, " R8"};
      return t;
   endfunction

   task automatic drive(input logic [5:0] c, input logic [2:0] p);
      item_t it;
      @(negedge clk);
      cfg = c;
      pin = p;
      it.exp  = model(c, p);
      it.tag  = tag_of(c);
      it.cfgv = c;
      it.pinv = p;
      sb_q.push_back(it);
   endtask

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // monitor: result of inputs driven before the edge is visible 5 ns after it
   always begin
      @(posedge clk);
      #5;
      if (rst_n && sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         check(out, it.exp, $sformatf("%s cfg=%0h pin=%0h", it.tag, it.cfgv, it.pinv));
      end
   end

   initial begin
      #4_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      cfg = 6'b100000;
      pin = 3'b111;
      repeat (3) @(posedge clk);
      #5;
      check(out, 1'b0, "R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      pin = 3'b000;
      cfg = 6'b000000;

      for (int c = 0; c < 64; c++) begin
         for (int p = 0; p < 8; p++) begin
            drive(6'(c), 3'(p));
         end
      end

      drive(6'b100000, 3'b111);
      drive(6'b100000, 3'b111);
      @(posedge clk);
      #5;
      check(out, 1'b1, "R2 held value before reset");
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(out, 1'b0, "R1 asynchronous clear");
      @(posedge clk);
      #5;
      check(out, 1'b0, "R1 held low in reset");
      if (sb_q.size() != 0) begin
         checks++;
         fails++;
         $display("FAIL R2 scoreboard leftover actual=%0d expected=0", sb_q.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule